// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block turns single-word requests from an internal valid/ready port into bus cycles for an asynchronous static RAM of 512K bytes. The bus has a 19-bit address, active-low chip select, output enable and write enable, and an 8-bit data bus. The data bus is split into an outgoing value, an incoming value and a drive enable, and the pad ring joins them. Each request is either a read or a write. A read returns its byte on a response port, marked by a one-cycle done pulse.

Every timing minimum of the memory is a parameter in nanoseconds. The clock period is also a parameter. From these the block derives whole-cycle counts, each rounded up. A read holds chip select and output enable low for the access interval, then releases the bus for the turnaround interval. A write pulses write enable low for the longest of the pulse-width, select-to-end, address-to-end and data-setup minimums. It keeps address and data for a hold cycle, then pads the access out to the minimum write cycle time. Between accesses the memory sits in standby.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and in every cycle in which `reqReady` is high, chip select, output enable and write enable are all high (standby), `memDqOe` is low and `rspValid` is low.
- R2: A read holds chip select and output enable low and write enable high for exactly ceil(max(tRC, tAA, tOE)/Tclk) cycles, 14 with the default 5 ns clock. The address stays stable for that whole interval.
- R3: Read data is sampled on the last clock edge of the read interval. It appears on `rspData` with `rspValid` high for exactly one cycle. That cycle is the 15th after the accepting edge at the defaults.
- R4: After the read interval, chip select and output enable stay high for ceil(tHZ/Tclk) cycles, 5 at the defaults, before `reqReady` returns. A read therefore keeps the block busy for 19 cycles.
- R5: A write drives write enable low for exactly ceil(max(tWP, tCW, tAW, tDW)/Tclk) cycles, 12 at the defaults. Chip select goes low with it and output enable stays high. `memDqOe` is high throughout, and address and data are stable.
- R6: When write enable rises, address and data are kept and `memDqOe` stays high for at least one more cycle. `memDqOe` never falls in the same cycle that write enable rises.
- R7: A write keeps the block busy for max(ceil(tWC/Tclk), pulse plus hold) cycles, 14 at the defaults.
- R8: `memDqOe` is never high while the memory is enabled to drive. It rises only after chip select or output enable has been high for at least the turnaround count.
- R9: `reqReady` is low for the whole of an access. Changes on the request inputs during that time do not change the address, the data written or the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 8 | Byte to write |
| rspValid | output | 1 | One-cycle done pulse for a read |
| rspData | output | 8 | Byte returned by a read |
| memAddr | output | 19 | Address bus to the memory |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqIn | input | 8 | Data received from the memory |
| memDqOe | output | 1 | Drive enable for the data pads |

## Verification
The case hardest to reach from the ports is a write that follows a read as closely as the controller allows. In that case the memory's output drivers may still be active when the controller wants the bus. The bench keeps a cycle-level memory model that drives data only after the full access time, and counts the cycles since the memory last drove. Write and read requests to the same addresses are issued back to back, each queued as soon as the previous one ends. Every cycle is then checked for overlap between the two drivers.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Strobes from the sequencer to the datapath; all pins active low except dqOe.
  typedef struct packed {
    logic csN;
    logic oeN;
    logic weN;
    logic dqOe;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REL,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WR_PAD
  } state_e;

  localparam strobe_t STROBE_IDLE = '{csN: 1'b1, oeN: 1'b1, weN: 1'b1, dqOe: 1'b0};

  // Whole cycles needed to cover a minimum given in nanoseconds.
  function automatic int nsToCycles(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_ctrl.sv
module sram_ctl_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 14,
  parameter int REL_CYC  = 5,
  parameter int WP_CYC   = 12,
  parameter int HOLD_CYC = 1,
  parameter int PAD_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    accept,
  output logic    capture,
  output strobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, REL_CYC), maxOf(maxOf(WP_CYC, HOLD_CYC), PAD_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_e state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic done;

  function automatic strobe_t decode(input state_e s);
    strobe_t v;
    v.csN  = !(s inside {ST_RD_ACC, ST_WR_PULSE, ST_WR_HOLD});
    v.oeN  = (s != ST_RD_ACC);
    v.weN  = (s != ST_WR_PULSE);
    v.dqOe = (s inside {ST_WR_PULSE, ST_WR_HOLD});
    return v;
  endfunction

  assign done     = (cnt == '0);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign capture  = (state == ST_RD_ACC) && done;

  always_comb begin
    stateNxt = state;
    cntNxt   = done ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (reqWrite) begin
            stateNxt = ST_WR_PULSE;
            cntNxt   = CNT_W'(WP_CYC - 1);
          end else begin
            stateNxt = ST_RD_ACC;
            cntNxt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (done) begin
          stateNxt = ST_RD_REL;
          cntNxt   = CNT_W'(REL_CYC - 1);
        end
      end
      ST_RD_REL: begin
        if (done) stateNxt = ST_IDLE;
      end
      ST_WR_PULSE: begin
        if (done) begin
          stateNxt = ST_WR_HOLD;
          cntNxt   = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WR_HOLD: begin
        if (done) begin
          if (PAD_CYC > 0) begin
            stateNxt = ST_WR_PAD;
            cntNxt   = CNT_W'(maxOf(PAD_CYC, 1) - 1);
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_WR_PAD: begin
        if (done) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the pins come straight off flops.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      strobe <= STROBE_IDLE;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      strobe <= decode(stateNxt);
    end
  end

  // Cycle counters used only by the checks below.
  logic [CNT_W:0] weLowCnt;
  logic [CNT_W:0] quietCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt <= '0;
      quietCnt <= (CNT_W+1)'(REL_CYC);
    end else begin
      weLowCnt <= strobe.weN ? '0 : weLowCnt + 1'b1;
      if (!strobe.csN && !strobe.oeN) quietCnt <= '0;
      else if (quietCnt < (CNT_W+1)'(REL_CYC)) quietCnt <= quietCnt + 1'b1;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (strobe.csN && strobe.oeN && strobe.weN && !strobe.dqOe)); // R1

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.weN) |-> (weLowCnt == (CNT_W+1)'(WP_CYC))); // R5

  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.dqOe) |-> $past(strobe.weN)); // R6

  AST_DQ_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.dqOe) |-> (quietCnt >= (CNT_W+1)'(REL_CYC))); // R8

  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dqOe |-> strobe.oeN); // R8

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic              capture,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  // Address and write data are latched once per access and held until the next one.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= capture;
      if (capture) rspData <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memCsN   = strobe.csN;
  assign memOeN   = strobe.oeN;
  assign memWeN   = strobe.weN;
  assign memDqOe  = strobe.dqOe;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr)); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R3

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 5,
  parameter int T_RC   = 70,
  parameter int T_AA   = 70,
  parameter int T_OE   = 35,
  parameter int T_HZ   = 25,
  parameter int T_WC   = 70,
  parameter int T_WP   = 50,
  parameter int T_CW   = 60,
  parameter int T_AW   = 60,
  parameter int T_DW   = 30,
  parameter int T_AH   = 5,
  parameter int T_DH   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  localparam int RD_CYC   = maxOf(1, nsToCycles(maxOf(T_RC, maxOf(T_AA, T_OE)), CLK_NS));
  localparam int REL_CYC  = maxOf(1, nsToCycles(T_HZ, CLK_NS));
  localparam int WP_CYC   = maxOf(1, nsToCycles(maxOf(maxOf(T_WP, T_DW), maxOf(T_CW, T_AW)), CLK_NS));
  localparam int HOLD_CYC = maxOf(1, nsToCycles(maxOf(T_AH, T_DH), CLK_NS));
  localparam int WC_CYC   = nsToCycles(T_WC, CLK_NS);
  localparam int PAD_CYC  = maxOf(0, WC_CYC - WP_CYC - HOLD_CYC);

  strobe_t strobe;
  logic    accept;
  logic    capture;

  sram_ctl_ctrl #(
    .RD_CYC  (RD_CYC),
    .REL_CYC (REL_CYC),
    .WP_CYC  (WP_CYC),
    .HOLD_CYC(HOLD_CYC),
    .PAD_CYC (PAD_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .accept  (accept),
    .capture (capture),
    .strobe  (strobe)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .accept  (accept),
    .capture (capture),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memCsN  (memCsN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOe (memDqOe),
    .rspValid(rspValid),
    .rspData (rspData)
  );

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

  localparam int CLK_NS   = 5;
  localparam int EXP_RD   = (70 + CLK_NS - 1) / CLK_NS;          // max(tRC,tAA,tOE)
  localparam int EXP_REL  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WP   = (60 + CLK_NS - 1) / CLK_NS;          // max(tWP,tCW,tAW,tDW)
  localparam int EXP_HOLD = 1;
  localparam int EXP_WC   = ((70 + CLK_NS - 1) / CLK_NS > EXP_WP + EXP_HOLD) ?
                            (70 + CLK_NS - 1) / CLK_NS : EXP_WP + EXP_HOLD;
  localparam int NADDR    = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [18:0] memAddr;
  logic        memCsN, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'hEE;

  int checks = 0;
  int fails = 0;
  bit mon = 1'b0;

  logic [7:0]  model [logic [18:0]];
  int          rdRun = 0;
  int          oeRun = 0;
  int          weRun = 0;
  int          sinceDrive = 100;
  logic        prevWeN = 1'b1;
  logic        prevOeN = 1'b1;
  logic        prevCsN = 1'b1;
  logic [18:0] prevAddr = '0;
  logic [7:0]  prevDq = '0;

  always #(CLK_NS * 500ps) clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] addrOf(input int i);
    if (i == 0) return 19'h00000;
    if (i == NADDR - 1) return 19'h7FFFF;
    return 19'((i * 21845 + i * i * 7) & 32'h7FFFF);
  endfunction

  // Memory model and bus monitor, evaluated between clock edges.
  always @(negedge clk) begin
    if (mon) begin
      bit drive;
      drive = !memCsN && !memOeN && memWeN;
      // write lands on the rising edge of write enable
      if (!prevWeN && memWeN) begin
        model[prevAddr] = prevDq;
        chk(weRun == EXP_WP, "R5 write pulse length", weRun, EXP_WP);
        chk(memDqOe && memAddr == prevAddr && memDqOut == prevDq, "R6 hold after write enable",
            {memDqOe, memAddr, memDqOut}, {1'b1, prevAddr, prevDq});
      end
      if (!memWeN) begin
        if (prevWeN) chk(!memCsN && prevCsN, "R5 select falls with write enable", memCsN, 0);
        if (!prevWeN && (memAddr != prevAddr || memDqOut != prevDq))
          chk(1'b0, "R5 address/data stable in pulse", memAddr, prevAddr);
        if (memCsN || !memOeN || !memDqOe)
          chk(1'b0, "R5 strobe levels in pulse", {memCsN, memOeN, memDqOe}, 3'b011);
        weRun++;
      end else begin
        weRun = 0;
      end
      if (prevOeN == 1'b0 && memOeN) chk(oeRun == EXP_RD, "R2 read strobe length", oeRun, EXP_RD);
      if (!memOeN) begin
        if (!prevOeN && memAddr != prevAddr) chk(1'b0, "R2 address stable in read", memAddr, prevAddr);
        oeRun++;
      end else begin
        oeRun = 0;
      end
      if (memDqOe && (drive || sinceDrive < EXP_REL))
        chk(1'b0, "R8 bus contention", sinceDrive, EXP_REL);
      if (drive) sinceDrive = 0; else if (sinceDrive < 100) sinceDrive++;
      if (reqReady && (!memCsN || !memOeN || !memWeN || memDqOe))
        chk(1'b0, "R1 standby while ready", {memCsN, memOeN, memWeN, memDqOe}, 4'b1110);
      // memory output: valid only after the full access time
      if (drive) rdRun++; else rdRun = 0;
      if (drive && rdRun >= EXP_RD) memDqIn = model.exists(memAddr) ? model[memAddr] : 8'h00;
      else memDqIn = 8'hEE;
      prevWeN = memWeN; prevOeN = memOeN; prevCsN = memCsN;
      prevAddr = memAddr; prevDq = memDqOut;
    end
  end

  task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        output int busy, output int rspAt, output int rspCnt, output logic [7:0] rdat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = !wr; reqAddr = ~a; reqWdata = ~d;   // R9 noise while busy
    busy = 0; rspAt = -1; rspCnt = 0; rdat = 8'h00;
    while (!reqReady && busy < 200) begin
      busy++;
      if (rspValid) begin rspCnt++; rspAt = busy; rdat = rspData; end
      if (!memCsN && memAddr != a) chk(1'b0, "R9 address held during access", memAddr, a);
      @(negedge clk);
    end
    if (rspValid) rspCnt++;
  endtask

  task automatic doWrite(input logic [18:0] a, input logic [7:0] d);
    int busy, at, cnt; logic [7:0] r;
    access(1'b1, a, d, busy, at, cnt, r);
    chk(busy == EXP_WC, "R7 write busy cycles", busy, EXP_WC);
    chk(cnt == 0, "R3 no response for write", cnt, 0);
  endtask

  task automatic doRead(input logic [18:0] a, input logic [7:0] expd);
    int busy, at, cnt; logic [7:0] r;
    access(1'b0, a, 8'h00, busy, at, cnt, r);
    chk(busy == EXP_RD + EXP_REL, "R4 read busy cycles", busy, EXP_RD + EXP_REL);
    chk(cnt == 1 && at == EXP_RD + 1, "R3 response timing", {cnt[7:0], at[7:0]}, {8'd1, 8'(EXP_RD + 1)});
    chk(r == expd, "R3 read data", r, expd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCsN && memOeN && memWeN && !memDqOe, "R1 reset strobes",
        {memCsN, memOeN, memWeN, memDqOe}, 4'b1110);
    chk(reqReady && !rspValid, "R1 reset ready/response", {reqReady, rspValid}, 2'b10);
    mon = 1'b1;

    for (int i = 0; i < NADDR; i++) doWrite(addrOf(i), 8'((i * 37 + 5) & 255));
    for (int i = NADDR - 1; i >= 0; i--) doRead(addrOf(i), 8'((i * 37 + 5) & 255));

    // back-to-back turnaround: write right after read and read right after write (R8)
    for (int i = 0; i < 8; i++) begin
      doRead(addrOf(i), (i == 0) ? 8'd5 : 8'(((i - 1) * 91 + 3) & 255) ^ 8'h00);
      doWrite(addrOf(i + 1), 8'((i * 91 + 3) & 255));
      doRead(addrOf(i + 1), 8'((i * 91 + 3) & 255));
    end

    doRead(19'h12345, 8'h00);   // never written

    repeat (3) @(negedge clk);
    chk(reqReady && memCsN && !memDqOe, "R1 idle after traffic", {reqReady, memCsN, memDqOe}, 3'b110);
    chk(sinceDrive >= EXP_REL, "R8 bus quiet at end", sinceDrive, EXP_REL);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule